// File: doc/BRIEF.md
# Processor-to-Host Message Channel

This block links a processor core to a host test environment. The core reports to the host by writing one word to a dedicated control register. Each write carries two things: a 2-bit message kind and a 16-bit payload. The block unpacks the write into a message and stores it in a small outbound queue. The host drains the queue over a valid/ready stream. A 32-bit integer does not fit in one message, so the core sends it as two messages, low half first and then high half. The queue keeps them in order.

The host starts the core with a start pulse and a start address; the usual address is 0x200. Until that pulse arrives, the run-enable and start-address outputs stay low. After the core is running, the block ignores any later start pulse. When the block accepts an exit message, it records a pass or fail verdict: a payload of zero means pass. From then on it discards every further register write, while still reporting that it accepted them.

Back-pressure works as follows. On the core side, `wr_ready` drops only while the queue is full and no exit has been recorded. The core must hold the write until it sees ready, so no message is lost. On the host side, a message stays at the head of the queue, with its fields unchanged, until the host asserts `msg_ready`.

Top module: `c2h_channel`

## Requirements
- R1: While `rst_n` is low, and on the first edge after reset, `run_en`, `run_pc`, `msg_valid`, `done` and `exit_pass` are all 0.
- R2: A cycle with `start_valid` high while `run_en` is low sets `run_en` to 1 and `run_pc` to `start_addr` from the next cycle on.
- R3: Once `run_en` is 1, it stays 1 and `run_pc` keeps its value until reset, whatever happens on `start_valid` and `start_addr`.
- R4: A write is accepted when `wr_valid` and `wr_ready` are both high. An accepted write made before `done` becomes a message whose kind is `wr_data[17:16]` and whose payload is `wr_data[15:0]`. Bits 31:18 have no effect. If the queue was empty, the message shows on `msg_valid`/`msg_type`/`msg_payload` in the next cycle.
- R5: Message kinds are encoded as 0 = exit code, 1 = character, 2 = integer low 16 bits, 3 = integer high 16 bits. Two consecutive writes carrying the low half and then the high half of an integer reach the host in that order.
- R6: The queue holds DEPTH messages (4 by default) in first-in first-out order. `wr_ready` is low exactly when the queue is full and `done` is 0, so no accepted message is dropped.
- R7: A message is removed when `msg_valid` and `msg_ready` are both high. While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_type` and `msg_payload` hold.
- R8: An accepted write of kind 0 made before `done` is queued like any other message. It also sets `done` to 1 in the next cycle, with `exit_pass` = 1 if its payload is 0 and 0 otherwise.
- R9: After `done` is 1, `wr_ready` is 1, writes are discarded (the queue gains nothing), and `done` and `exit_pass` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Host start pulse |
| start_addr | input | 32 | Address where execution begins |
| run_en | output | 1 | Core may run |
| run_pc | output | 32 | Start address captured from the host |
| wr_valid | input | 1 | Core writes the to-host register |
| wr_ready | output | 1 | Write may complete this cycle |
| wr_data | input | 32 | Written value: [17:16] kind, [15:0] payload |
| msg_valid | output | 1 | A message is at the queue head |
| msg_ready | input | 1 | Host takes the head message |
| msg_type | output | 2 | Kind of the head message |
| msg_payload | output | 16 | Payload of the head message |
| done | output | 1 | Exit message recorded |
| exit_pass | output | 1 | Recorded exit code was zero |

## Verification
Every result is due exactly one clock edge after the input that causes it:
- a start pulse shows on `run_en` and `run_pc`;
- an accepted write into an empty queue shows at the head;
- a pop reveals the next entry;
- an exit write sets `done` and `exit_pass`.

The write-ready signal is combinational. It reflects the queue occupancy and `done` in the same cycle. The bench drives its inputs on the falling edge. At the next falling edge it first advances a behavioural model by the one rising edge in between, and then compares every output with that model. As a result, every comparison sits exactly one register stage after the stimulus that caused it.

// File: rtl/c2h_pkg.sv
package c2h_pkg;
  typedef enum logic [1:0] {
    KIND_EXIT    = 2'd0,
    KIND_CHAR    = 2'd1,
    KIND_INT_LO  = 2'd2,
    KIND_INT_HI  = 2'd3
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e   kind;
    logic [15:0] payload;
  } msg_t;

  localparam int unsigned KIND_LSB = 16;
  localparam int unsigned MSG_W    = $bits(msg_t);
endpackage

// File: rtl/c2h_fifo.sv
module c2h_fifo #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/c2h_start_ctl.sv
module c2h_start_ctl #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              run_en,
  output logic [ADDR_W-1:0] run_pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      run_pc <= '0;
    end else if (start_valid && !run_en) begin
      run_en <= 1'b1;
      run_pc <= start_addr;
    end
  end
endmodule

// File: rtl/c2h_exit_trk.sv
module c2h_exit_trk
  import c2h_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  msg_t msg,
  output logic done,
  output logic exit_pass
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      exit_pass <= 1'b0;
    end else if (push && !done && msg.kind == KIND_EXIT) begin
      done      <= 1'b1;
      exit_pass <= (msg.payload == 16'd0);
    end
  end
endmodule

// File: rtl/c2h_channel.sv
module c2h_channel
  import c2h_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              run_en,
  output logic [ADDR_W-1:0] run_pc,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_type,
  output logic [15:0]       msg_payload,
  output logic              done,
  output logic              exit_pass
);
  msg_t in_msg, head_msg;
  logic fifo_empty, fifo_full, enq;

  assign in_msg.kind    = msg_kind_e'(wr_data[KIND_LSB+1:KIND_LSB]);
  assign in_msg.payload = wr_data[15:0];

  assign wr_ready = done || !fifo_full;
  assign enq      = wr_valid && wr_ready && !done;

  c2h_start_ctl #(.ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_addr(start_addr),
    .run_en(run_en), .run_pc(run_pc)
  );

  c2h_fifo #(.W(MSG_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(enq), .push_data(in_msg),
    .pop(msg_ready), .head(head_msg),
    .empty(fifo_empty), .full(fifo_full)
  );

  c2h_exit_trk u_exit (
    .clk(clk), .rst_n(rst_n),
    .push(enq), .msg(in_msg),
    .done(done), .exit_pass(exit_pass)
  );

  assign msg_valid   = !fifo_empty;
  assign msg_type    = head_msg.kind;
  assign msg_payload = head_msg.payload;
endmodule

// File: rtl/c2h_channel_chk.sv
module c2h_channel_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic [ADDR_W-1:0] start_addr,
  input logic              run_en,
  input logic [ADDR_W-1:0] run_pc,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [1:0]        msg_type,
  input logic [15:0]       msg_payload,
  input logic              done,
  input logic              exit_pass
);
  localparam int unsigned OCC_W = $clog2(DEPTH + 1) + 1;
  logic [OCC_W-1:0] occ;
  logic acc_in, acc_out;

  assign acc_in  = wr_valid && wr_ready && !done;
  assign acc_out = msg_valid && msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + OCC_W'(acc_in) - OCC_W'(acc_out);
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !run_en) |=> (run_en && run_pc == $past(start_addr)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> (run_en && $stable(run_pc)));

  p_first_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_in && !msg_valid) |=> (msg_valid && msg_type == $past(wr_data[17:16])
                                && msg_payload == $past(wr_data[15:0])));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ <= OCC_W'(DEPTH)) && (msg_valid == (occ != '0)));

  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == (done || occ < OCC_W'(DEPTH)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type) && $stable(msg_payload)));

  p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_in && wr_data[17:16] == 2'd0) |=> (done && exit_pass == ($past(wr_data[15:0]) == 16'd0)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && wr_ready && $stable(exit_pass)));
endmodule

bind c2h_channel c2h_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
  .run_en(run_en), .run_pc(run_pc), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_type(msg_type), .msg_payload(msg_payload), .done(done), .exit_pass(exit_pass)
);

// File: tb/c2h_channel_bench.sv
`timescale 1ns/1ps
module c2h_channel_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic [31:0] start_addr = '0;
  logic        run_en;
  logic [31:0] run_pc;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [1:0]  msg_type;
  logic [15:0] msg_payload;
  logic        done, exit_pass;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [17:0] mq[$];
  logic        m_run, m_done, m_pass;
  logic [31:0] m_pc;

  always #2.5 clk = ~clk;

  c2h_channel u_c2h_channel (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .run_en(run_en), .run_pc(run_pc), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_type(msg_type), .msg_payload(msg_payload), .done(done), .exit_pass(exit_pass)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    mq.delete();
    m_run = 0; m_done = 0; m_pass = 0; m_pc = '0;
  endtask

  // advance the model by the rising edge that just passed
  task automatic model_step();
    bit acc, pop;
    acc = wr_valid && (m_done || mq.size() < DEPTH);
    pop = msg_ready && mq.size() > 0;
    if (pop) void'(mq.pop_front());
    if (acc && !m_done) begin
      mq.push_back(wr_data[17:0]);
      if (wr_data[17:16] == 2'd0) begin
        m_done = 1;
        m_pass = (wr_data[15:0] == 16'd0);
      end
    end
    if (start_valid && !m_run) begin
      m_run = 1;
      m_pc = start_addr;
    end
  endtask

  task automatic compare();
    check("R2/R3 run_en", {31'd0, run_en}, {31'd0, m_run});
    check("R2/R3 run_pc", run_pc, m_pc);
    check("R6/R9 wr_ready", {31'd0, wr_ready}, {31'd0, m_done || mq.size() < DEPTH});
    check("R6/R7 msg_valid", {31'd0, msg_valid}, {31'd0, mq.size() > 0});
    if (mq.size() > 0) begin
      check("R4/R5 msg_type", {30'd0, msg_type}, {30'd0, mq[0][17:16]});
      check("R4/R5 msg_payload", {16'd0, msg_payload}, {16'd0, mq[0][15:0]});
    end
    check("R8/R9 done", {31'd0, done}, {31'd0, m_done});
    check("R8/R9 exit_pass", {31'd0, exit_pass}, {31'd0, m_pass});
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start_valid = 0; wr_valid = 0; msg_ready = 0; wr_data = '0;
    repeat (2) @(negedge clk);
    model_clear();
    check("R1 reset run_en", {31'd0, run_en}, 32'd0);
    check("R1 reset msg_valid", {31'd0, msg_valid}, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    rst_n = 1;
    tick();
  endtask

  task automatic random_traffic(input int cycles, input bit allow_exit);
    for (int i = 0; i < cycles; i++) begin
      wr_valid = ($urandom % 2) == 0;
      wr_data = $urandom;
      if (!allow_exit && wr_data[17:16] == 2'd0) wr_data[17:16] = 2'd1 + 2'($urandom % 3);
      if (allow_exit && ($urandom % 8) != 0 && wr_data[17:16] == 2'd0) wr_data[17:16] = 2'd2;
      msg_ready = ($urandom % 3) != 0;
      start_valid = ($urandom % 5) == 0;
      start_addr = $urandom;
      tick();
    end
    start_valid = 0; wr_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();                                   // R1
    // R2: start at 0x200
    start_valid = 1; start_addr = 32'h200; tick();
    // R3: later starts ignored
    start_addr = 32'h1234; tick(); tick();
    start_valid = 0;
    // R5/R6: fill with back-pressure, high bits garbage (R4), int split low then high
    msg_ready = 0; wr_valid = 1;
    for (int i = 0; i < 6; i++) begin
      wr_data = {14'h3FFF, 2'(1 + (i % 3)), 16'(16'hA000 + i)};
      tick();
    end
    wr_valid = 0;
    // R7: held head while stalled
    tick(); tick();
    msg_ready = 1;
    for (int i = 0; i < 6; i++) tick();
    msg_ready = 0;
    // R5: integer halves in order
    wr_valid = 1; wr_data = {16'h0, 2'd2, 14'h0} | 32'h0000_BEEF & 32'h0003_FFFF; wr_data[17:16] = 2'd2; tick();
    wr_data = 32'hFFFE_1234; wr_data[17:16] = 2'd3; tick();
    wr_valid = 0; msg_ready = 1; tick(); tick(); tick();
    random_traffic(300, 0);
    // R8: exit pass
    wr_valid = 1; msg_ready = 0; wr_data = 32'hFFFC_0000; tick();
    // R9: further writes discarded
    wr_data = 32'h0001_0041; tick(); tick();
    wr_data = 32'h0000_0007; tick();
    wr_valid = 0; msg_ready = 1;
    for (int i = 0; i < 8; i++) tick();
    // second run: exit fail, then random with exits
    do_reset();
    start_valid = 1; start_addr = 32'h200; tick(); start_valid = 0;
    wr_valid = 1; wr_data = 32'h0000_0005; tick();    // R8 fail code
    wr_valid = 0; tick();
    random_traffic(200, 1);
    do_reset();
    random_traffic(2000, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule